// File: doc/BRIEF.md
# Sensorless Motor Startup Sequencer

This block brings a three-phase sensorless motor from rest, or from coasting, to the point where closed-loop commutation takes over. When enabled, it first leaves all phases floating. It watches two phase comparators until the rotor is judged to be still. It then pulls the rotor into a known position with a slowly ramped drive, releases it to open-loop acceleration, and hands control to the closed-loop algorithm once the open-loop electrical frequency reaches a threshold. That threshold is picked by a 4-bit configuration code.

An external open-loop generator supplies the current electrical frequency and a pulse for each commutation step. The sequencer keeps the commutation sector index and steps it forward or backward according to a direction bit captured at the start of the run. Removing the run enable (sleep, or a fault being cleared upstream) returns the block to idle. Raising it again replays the whole sequence from the start. The comparators themselves and the closed-loop algorithm are outside this block.

Top module: `motor_start_seq`

## Requirements
- R1: Under synchronous active-low reset, state_o is 0, all enables and duties are 0, handoff_o is 0 and sector_o is 0.
- R2: The state codes are IDLE=0, SPEED_DETECT=1, ALIGN=2, OPEN_LOOP=3, CLOSED_LOOP=4. With run_en high, IDLE goes to SPEED_DETECT on the next clock. With run_en low, any state goes to IDLE on the next clock. A new run restarts every timer, the duty ramp and the sector from zero.
- R3: In SPEED_DETECT every phase floats (enables 0, duties 0). The block moves to ALIGN after ISD_QUIET_CYC consecutive cycles with no rising edge on either comparator. Each comparator passes a two-flop synchronizer first. Any rising edge restarts the quiet window.
- R4: In ALIGN all three enables are 1 and duty_u is 0. duty_v and duty_w are equal to min(2^(DUTY_W-1), floor(n / RAMP_STEP_CYC)), where n counts cycles since entering ALIGN and starts at 0.
- R5: ALIGN lasts exactly ALIGN_CYC cycles and is followed by OPEN_LOOP.
- R6: The handoff threshold is in half-hertz units of ol_freq. Code c from 1 to 15 gives 25*c (12.5 Hz per step), and code 0 gives 175 (87.5 Hz).
- R7: In OPEN_LOOP, if ol_freq is greater than or equal to the threshold, the next state is CLOSED_LOOP and handoff_o is high for exactly that first CLOSED_LOOP cycle. Below the threshold the state stays in OPEN_LOOP.
- R8: In OPEN_LOOP and CLOSED_LOOP, each step_tick moves sector_o (0..5) to (s+1) mod 6 when the captured direction is 0 (U, V, W order), or to (s+5) mod 6 when it is 1 (U, W, V order). step_tick has no effect in other states. dir_rev is sampled in IDLE, and changes made during a run have no effect.
- R9: In OPEN_LOOP and CLOSED_LOOP all enables are 1 and all three duty outputs are 0, because the amplitude there belongs to the downstream drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Run enable; low means sleep or fault |
| cmp_a | input | 1 | First phase-to-phase comparator (asynchronous) |
| cmp_b | input | 1 | Second phase-to-phase comparator (asynchronous) |
| cfg_code | input | 4 | Handoff threshold selection code |
| dir_rev | input | 1 | Direction: 0 = U,V,W order, 1 = U,W,V order |
| ol_freq | input | FREQ_W | Open-loop electrical frequency, half-hertz units |
| step_tick | input | 1 | One-cycle commutation step pulse |
| state_o | output | 3 | Sequencer state code |
| duty_u | output | DUTY_W | Phase U duty |
| duty_v | output | DUTY_W | Phase V duty |
| duty_w | output | DUTY_W | Phase W duty |
| en_u | output | 1 | Phase U driver enable |
| en_v | output | 1 | Phase V driver enable |
| en_w | output | 1 | Phase W driver enable |
| handoff_o | output | 1 | Single-cycle strobe on entering closed loop |
| sector_o | output | 3 | Commutation sector index 0..5 |

## Verification
The hardest case to reach from the ports is a coasting rotor whose comparator edges arrive just under the quiet window. The detector must keep restarting its window, and after the final edge it must wait a full window that starts only once the edge has crossed the synchronizer. The stimulus toggles the two comparators in turn with random periods below the window. It then pins the exact cycle at which ALIGN appears, counted from the last rising edge including the synchronizer latency. Handoff is exercised with random codes plus codes 0 and 15, with the frequency held just below and then at or above the decoded threshold. Steps and direction flips are also injected in states where they must be ignored.

// File: rtl/motor_start_pkg.sv
// Package: shared state encoding and handoff threshold decode for the
// startup sequencer. Assumes frequencies are expressed in half-hertz units.
package motor_start_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ISD    = 3'd1,
        ST_ALIGN  = 3'd2,
        ST_OPEN   = 3'd3,
        ST_CLOSED = 3'd4
    } start_state_e;

    localparam int THRESH_W        = 9;
    localparam int HALF_HZ_PER_STEP = 25;   // 12.5 Hz per code step
    localparam int CODE0_THRESH     = 175;  // 87.5 Hz for code zero

    // Decode the 4-bit code into a handoff threshold in half-hertz units.
    function automatic logic [THRESH_W-1:0] handoff_thresh(input logic [3:0] code);
        if (code == 4'd0)
            return THRESH_W'(CODE0_THRESH);
        else
            return THRESH_W'({5'd0, code} * THRESH_W'(HALF_HZ_PER_STEP));
    endfunction

endpackage

// File: rtl/isd_quiet_detect.sv
// Initial speed detect: synchronizes the two comparator inputs, finds rising
// edges on either one, and reports when QUIET_CYC consecutive cycles have
// passed without an edge. Assumes clear_i is held while not detecting.
module isd_quiet_detect #(
    parameter int QUIET_CYC   = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic cmp_a,
    input  logic cmp_b,
    output logic quiet_o
);
    localparam int CW = $clog2(QUIET_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(QUIET_CYC - 1);

    logic [1:0] cmp_raw;
    logic [1:0] cmp_sync;
    logic [1:0] cmp_prev;
    logic       rise;
    logic [CW-1:0] quiet_cnt;

    assign cmp_raw = {cmp_b, cmp_a};

    generate
        for (genvar g = 0; g < 2; g++) begin : g_sync
            logic [SYNC_STAGES-1:0] chain;
            // Bring one asynchronous comparator into the clock domain.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain <= '0;
                else
                    chain <= {chain[SYNC_STAGES-2:0], cmp_raw[g]};
            end
            assign cmp_sync[g] = chain[SYNC_STAGES-1];
        end
    endgenerate

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp_prev <= '0;
        else
            cmp_prev <= cmp_sync;
    end

    assign rise = |(cmp_sync & ~cmp_prev);

    // Count cycles since the last rising edge, saturating at the window end.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i || rise)
            quiet_cnt <= '0;
        else if (quiet_cnt != LAST)
            quiet_cnt <= quiet_cnt + 1'b1;
    end

    assign quiet_o = !clear_i && !rise && (quiet_cnt == LAST);

endmodule

// File: rtl/align_ramp.sv
// Align stage timing: raises the align duty by one LSB every STEP_CYC cycles
// up to half scale, and flags the last cycle of an ALIGN_CYC long stage.
// Assumes ALIGN_CYC covers the full ramp and clear_i is held outside align.
module align_ramp #(
    parameter int DUTY_W    = 9,
    parameter int STEP_CYC  = 4,
    parameter int ALIGN_CYC = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    output logic [DUTY_W-1:0] duty_o,
    output logic              done_o
);
    localparam int SW = $clog2(STEP_CYC + 1);
    localparam int AW = $clog2(ALIGN_CYC + 1);
    localparam logic [SW-1:0] STEP_LAST  = SW'(STEP_CYC - 1);
    localparam logic [AW-1:0] ALIGN_LAST = AW'(ALIGN_CYC - 1);
    localparam logic [DUTY_W-1:0] HALF   = DUTY_W'(1) << (DUTY_W - 1);

    logic [SW-1:0] step_cnt;
    logic [AW-1:0] align_cnt;

    // Track total time spent in the align stage.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)
            align_cnt <= '0;
        else if (align_cnt != ALIGN_LAST)
            align_cnt <= align_cnt + 1'b1;
    end

    // Step the duty upward on each step period until half scale is reached.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            step_cnt <= '0;
            duty_o   <= '0;
        end else if (step_cnt == STEP_LAST) begin
            step_cnt <= '0;
            if (duty_o != HALF)
                duty_o <= duty_o + 1'b1;
        end else begin
            step_cnt <= step_cnt + 1'b1;
        end
    end

    assign done_o = !clear_i && (align_cnt == ALIGN_LAST);

endmodule

// File: rtl/handoff_detect.sv
// Handoff threshold: decodes the configuration code and reports when the
// open-loop frequency is at or above it. Assumes FREQ_W holds 375.
module handoff_detect
    import motor_start_pkg::*;
#(
    parameter int FREQ_W = 12
) (
    input  logic [3:0]        code_i,
    input  logic [FREQ_W-1:0] freq_i,
    output logic              reached_o
);
    logic [THRESH_W-1:0] thresh;
    logic [FREQ_W-1:0]   thresh_ext;

    // Decode the threshold and compare against the live frequency.
    always_comb begin
        thresh     = handoff_thresh(code_i);
        thresh_ext = FREQ_W'(thresh);
        reached_o  = (freq_i >= thresh_ext);
    end

endmodule

// File: rtl/comm_sector.sv
// Commutation sector counter: captures the direction while idle and steps a
// six-sector index forward or backward on each enabled tick.
module comm_sector (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idle_i,
    input  logic       dir_i,
    input  logic       advance_i,
    output logic [2:0] sector_o
);
    localparam logic [2:0] LAST_SEC = 3'd5;

    logic dir_q;

    // Hold the direction captured during idle for the whole run.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir_q <= 1'b0;
        else if (idle_i)
            dir_q <= dir_i;
    end

    // Move the sector index in the captured direction.
    always_ff @(posedge clk) begin
        if (!rst_n || idle_i)
            sector_o <= '0;
        else if (advance_i) begin
            if (!dir_q)
                sector_o <= (sector_o == LAST_SEC) ? 3'd0 : sector_o + 3'd1;
            else
                sector_o <= (sector_o == 3'd0) ? LAST_SEC : sector_o - 3'd1;
        end
    end

endmodule

// File: rtl/motor_start_seq.sv
// Startup sequencer top: steps through idle, speed detect, align, open loop
// and closed loop; drives phase enables and align duties and strobes the
// handoff. Assumes the open-loop generator supplies frequency and step ticks.
module motor_start_seq
    import motor_start_pkg::*;
#(
    parameter int ISD_QUIET_CYC = 4_000_000,
    parameter int RAMP_STEP_CYC = 58_594,
    parameter int ALIGN_CYC     = 32_000_000,
    parameter int DUTY_W        = 9,
    parameter int FREQ_W        = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              cmp_a,
    input  logic              cmp_b,
    input  logic [3:0]        cfg_code,
    input  logic              dir_rev,
    input  logic [FREQ_W-1:0] ol_freq,
    input  logic              step_tick,
    output logic [2:0]        state_o,
    output logic [DUTY_W-1:0] duty_u,
    output logic [DUTY_W-1:0] duty_v,
    output logic [DUTY_W-1:0] duty_w,
    output logic              en_u,
    output logic              en_v,
    output logic              en_w,
    output logic              handoff_o,
    output logic [2:0]        sector_o
);
    start_state_e      cur_q, nxt;
    logic              quiet, align_done, freq_reached;
    logic              driving;
    logic [DUTY_W-1:0] ramp_duty;

    isd_quiet_detect #(.QUIET_CYC(ISD_QUIET_CYC), .SYNC_STAGES(2)) isd_i (
        .clk(clk), .rst_n(rst_n), .clear_i(cur_q != ST_ISD),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .quiet_o(quiet)
    );

    align_ramp #(.DUTY_W(DUTY_W), .STEP_CYC(RAMP_STEP_CYC), .ALIGN_CYC(ALIGN_CYC)) ramp_i (
        .clk(clk), .rst_n(rst_n), .clear_i(cur_q != ST_ALIGN),
        .duty_o(ramp_duty), .done_o(align_done)
    );

    handoff_detect #(.FREQ_W(FREQ_W)) hand_i (
        .code_i(cfg_code), .freq_i(ol_freq), .reached_o(freq_reached)
    );

    comm_sector sect_i (
        .clk(clk), .rst_n(rst_n), .idle_i(cur_q == ST_IDLE), .dir_i(dir_rev),
        .advance_i(step_tick && (cur_q == ST_OPEN || cur_q == ST_CLOSED)),
        .sector_o(sector_o)
    );

    // Choose the next sequencer state; a dropped enable always wins.
    always_comb begin
        nxt = cur_q;
        if (!run_en)
            nxt = ST_IDLE;
        else begin
            case (cur_q)
                ST_IDLE:   nxt = ST_ISD;
                ST_ISD:    if (quiet)        nxt = ST_ALIGN;
                ST_ALIGN:  if (align_done)   nxt = ST_OPEN;
                ST_OPEN:   if (freq_reached) nxt = ST_CLOSED;
                ST_CLOSED: nxt = ST_CLOSED;
                default:   nxt = ST_IDLE;
            endcase
        end
    end

    // Register the state and the one-cycle handoff strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q     <= ST_IDLE;
            handoff_o <= 1'b0;
        end else begin
            cur_q     <= nxt;
            handoff_o <= run_en && (cur_q == ST_OPEN) && freq_reached;
        end
    end

    // Map the state onto phase enables and align duties.
    always_comb begin
        driving = (cur_q == ST_ALIGN) || (cur_q == ST_OPEN) || (cur_q == ST_CLOSED);
        en_u    = driving;
        en_v    = driving;
        en_w    = driving;
        duty_u  = '0;
        duty_v  = (cur_q == ST_ALIGN) ? ramp_duty : '0;
        duty_w  = (cur_q == ST_ALIGN) ? ramp_duty : '0;
        state_o = cur_q;
    end

endmodule

// File: rtl/motor_start_chk.sv
// Checker for the startup sequencer, attached to the top by bind. Watches
// only ports of the top module.
module motor_start_chk #(
    parameter int DUTY_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_en,
    input logic [2:0]        state_o,
    input logic [DUTY_W-1:0] duty_u,
    input logic [DUTY_W-1:0] duty_v,
    input logic [DUTY_W-1:0] duty_w,
    input logic              en_u,
    input logic              en_v,
    input logic              en_w,
    input logic              handoff_o,
    input logic [2:0]        sector_o
);
    localparam logic [DUTY_W-1:0] HALF = DUTY_W'(1) << (DUTY_W - 1);

    assert_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> state_o == 3'd0);

    assert_float_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 || state_o == 3'd1) |-> (!en_u && !en_v && !en_w && duty_v == '0));

    assert_align_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 3'd2 |-> (duty_u == '0 && duty_v == duty_w && duty_v <= HALF));

    assert_ramp_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2 && $past(state_o) == 3'd2) |->
        (duty_v == $past(duty_v) || duty_v == DUTY_W'($past(duty_v) + 1'b1)));

    assert_open_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd3 && $past(state_o) != 3'd3) |-> $past(state_o) == 3'd2);

    assert_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        handoff_o |-> (state_o == 3'd4 && $past(state_o) == 3'd3));

    assert_sector_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sector_o <= 3'd5);

endmodule

bind motor_start_seq motor_start_chk #(.DUTY_W(DUTY_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .state_o(state_o),
    .duty_u(duty_u), .duty_v(duty_v), .duty_w(duty_w),
    .en_u(en_u), .en_v(en_v), .en_w(en_w),
    .handoff_o(handoff_o), .sector_o(sector_o)
);

// File: tb/motor_start_seq_tb_top.sv
module motor_start_seq_tb_top;
    localparam int T      = 40;
    localparam int STEP   = 2;
    localparam int ACYC   = 48;
    localparam int DW     = 5;
    localparam int FW     = 10;
    localparam int HALF   = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 1'b0, cmp_a = 1'b0, cmp_b = 1'b0, dir_rev = 1'b0, step_tick = 1'b0;
    logic [3:0] cfg_code = 4'd0;
    logic [FW-1:0] ol_freq = '0;
    logic [2:0] state_o, sector_o;
    logic [DW-1:0] duty_u, duty_v, duty_w;
    logic en_u, en_v, en_w, handoff_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    motor_start_seq #(.ISD_QUIET_CYC(T), .RAMP_STEP_CYC(STEP), .ALIGN_CYC(ACYC),
                      .DUTY_W(DW), .FREQ_W(FW)) dut_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .cfg_code(cfg_code), .dir_rev(dir_rev), .ol_freq(ol_freq), .step_tick(step_tick),
        .state_o(state_o), .duty_u(duty_u), .duty_v(duty_v), .duty_w(duty_w),
        .en_u(en_u), .en_v(en_v), .en_w(en_w), .handoff_o(handoff_o), .sector_o(sector_o)
    );

    function automatic int exp_thr(input int code);
        return (code == 0) ? 175 : 25 * code;
    endfunction

    function automatic int exp_duty(input int n);
        return (n / STEP > HALF) ? HALF : n / STEP;
    endfunction

    function automatic int next_sec(input int s, input bit rev);
        return rev ? (s + 5) % 6 : (s + 1) % 6;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // R2: drop then raise the enable; returns at the first detect cycle.
    task automatic start_seq(input bit rev);
        @(negedge clk); run_en = 1'b0;
        @(negedge clk); dir_rev = rev; run_en = 1'b1;
        @(negedge clk);
    endtask

    // Exact walk through detect and align, with ignored ticks and dir flips.
    task automatic walk_to_open(input bit rev);
        for (int i = 1; i <= T; i++) begin
            chk(state_o == 3'd1, "R3 detect state", state_o, 1);
            chk(!en_u && !en_v && !en_w && duty_v == 0, "R3 phases float", en_u, 0);
            chk(sector_o == 3'd0, "R8 tick ignored in detect", sector_o, 0);
            step_tick = ($urandom % 2) == 1;
            dir_rev = (i > 2) ? ~rev : rev;
            @(negedge clk);
        end
        step_tick = 1'b0;
        for (int n = 0; n < ACYC; n++) begin
            chk(state_o == 3'd2, "R5 align state", state_o, 2);
            chk(duty_v == DW'(exp_duty(n)) && duty_w == DW'(exp_duty(n)), "R4 ramp duty", duty_v, exp_duty(n));
            chk(duty_u == 0 && en_u && en_v && en_w, "R4 U grounded, all enabled", duty_u, 0);
            step_tick = ($urandom % 2) == 1;
            @(negedge clk);
        end
        step_tick = 1'b0;
        chk(state_o == 3'd3, "R5 align to open", state_o, 3);
        chk(duty_v == 0 && en_w && sector_o == 0, "R9 open drive", duty_v, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            report();
            $finish;
        end
    end

    initial begin
        int unsigned sd;
        int k;
        sd = $urandom(32'd7351);
        repeat (4) @(negedge clk);
        // R1 reset values
        chk(state_o == 0 && handoff_o == 0 && sector_o == 0, "R1 reset state", state_o, 0);
        chk(!en_u && !en_v && !en_w && duty_u == 0 && duty_v == 0 && duty_w == 0, "R1 reset outputs", duty_v, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(state_o == 0, "R2 stays idle without enable", state_o, 0);

        // R3 toggling comparators hold detect; exact exit after last edge
        start_seq(1'b0);
        for (int p = 0; p < 12; p++) begin
            int per;
            bit useb;
            per = 10 + int'($urandom % 21);
            useb = p[0];
            if (useb) cmp_b = 1'b1; else cmp_a = 1'b1;
            for (int c = 0; c < per; c++) begin
                if (c == per / 2) begin cmp_a = 1'b0; cmp_b = 1'b0; end
                @(negedge clk);
                chk(state_o == 3'd1, "R3 edges keep detect", state_o, 1);
            end
        end
        cmp_a = 1'b1;
        repeat (T + 2) @(negedge clk);
        chk(state_o == 3'd1, "R3 window restarted by last edge", state_o, 1);
        @(negedge clk);
        chk(state_o == 3'd2, "R3 quiet window ends", state_o, 2);

        // R2 drop enable during align, then restart from zero
        repeat (10) @(negedge clk);
        run_en = 1'b0;
        @(negedge clk);
        chk(state_o == 0 && !en_v && duty_v == 0, "R2 enable drop to idle", state_o, 0);
        run_en = 1'b1;
        @(negedge clk);
        chk(state_o == 3'd1 && sector_o == 0, "R2 restart in detect", state_o, 1);
        walk_to_open(1'b0);

        // R6 R7 R8 random and directed handoff runs
        for (int it = 0; it < 30; it++) begin
            bit rev;
            int code, thr, es, nb;
            rev  = ($urandom % 2) == 1;
            code = (it == 0) ? 0 : (it == 1) ? 15 : (it == 2) ? 1 : int'($urandom % 16);
            thr  = exp_thr(code);
            start_seq(rev);
            walk_to_open(rev);
            es = 0;
            cfg_code = 4'(code);
            nb = 1 + int'($urandom % 10);
            for (int c = 0; c < nb; c++) begin
                step_tick = ($urandom % 2) == 1;
                ol_freq = FW'(thr - 1 - int'($urandom % 20));
                if (c == 0) ol_freq = FW'(thr - 1);
                @(negedge clk);
                if (step_tick) es = next_sec(es, rev);
                chk(state_o == 3'd3 && !handoff_o, "R7 below threshold stays open", state_o, 3);
                chk(sector_o == 3'(es), "R8 open-loop sector step", sector_o, es);
            end
            step_tick = 1'b0;
            ol_freq = FW'(thr + ((it < 3) ? 0 : int'($urandom % 3)));
            @(negedge clk);
            chk(state_o == 3'd4, "R6 threshold decode reached", state_o, 4);
            chk(handoff_o == 1'b1, "R7 handoff strobe", handoff_o, 1);
            k = 1 + int'($urandom % 4);
            for (int c = 0; c < k; c++) begin
                step_tick = 1'b1;
                @(negedge clk);
                es = next_sec(es, rev);
                chk(handoff_o == 1'b0 && state_o == 3'd4, "R7 single-cycle strobe", handoff_o, 0);
                chk(sector_o == 3'(es), "R8 closed-loop sector step", sector_o, es);
                chk(en_u && en_v && en_w && duty_w == 0, "R9 closed drive", duty_w, 0);
            end
            step_tick = 1'b0;
            ol_freq = '0;
        end

        done = 1'b1;
        report();
        $finish;
    end
endmodule